// File: doc/BRIEF.md
# Keypad Column Strobe Driver

This block drives the column lines of a key matrix and turns the row lines into a keyboard interrupt. A small write/read register interface holds two values. The first is a column drive mode. It can drive every column high, drive every column low, float every column, or drive one chosen column high while the others float. The second is a row-select mask. Each column pad has its own output-enable and data bit, so the pad logic can produce all three drive states.

The row inputs come from a general-purpose input port and can change at any time. They pass through a two-stage synchroniser. The synchronised rows are ANDed with the mask and ORed into one signal. A registered copy of that signal is a level interrupt, which falls again by itself once every selected row is low. A combinational copy is a wake request for low-power states. The wake request still follows the rows while the peripheral clock enable is low. With the enable low, register writes and the interrupt flop are held frozen.

Top module: `keypad_strobe_drv`

## Requirements
- R1: While `rst_n` is low, at the next rising clock edge the block resets. After that edge `col_oe` is 0x00, `col_out` is 0x00, the mode reads back as 2 (all floating), the mask reads back as 0x00, and `kbd_irq` and `kbd_wake` are 0.
- R2: Mode code 0 drives every column high: `col_oe` = 0xFF and `col_out` = 0xFF.
- R3: Mode code 1 drives every column low: `col_oe` = 0xFF and `col_out` = 0x00.
- R4: Mode codes 2 to 7 float every column: `col_oe` = 0x00 and `col_out` = 0x00.
- R5: Mode codes 8 to 15 drive column (code − 8) high and float the other columns. Both `col_oe` and `col_out` equal 1 << (code − 8).
- R6: `kbd_wake` is the OR of the synchronised rows ANDed with the mask. A row change reaches `kbd_wake` after exactly two rising edges. Rows whose mask bit is 0 have no effect.
- R7: `kbd_irq` is a level signal. When `clk_en` is high it equals the value `kbd_wake` had one edge earlier, and it returns to 0 with no register write once the selected rows are low.
- R8: When `clk_en` is low, register writes are ignored and `kbd_irq` holds its value, while `kbd_wake` still follows the rows (R6).
- R9: Register address 0 holds the mode in write-data bits [3:0]; bits [7:4] are ignored and read back as 0. Address 1 holds the row mask, where bit i selects row i. `reg_rdata` shows the addressed register combinationally. A write takes effect at the edge on which `reg_we` and `clk_en` are both high.
- R10: A column whose output-enable is 0 always has `col_out` = 0 for that bit.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Peripheral clock enable; gates register writes and the interrupt flop |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 mode, 1 row mask |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Readback of the addressed register |
| row_in | input | 8 | Asynchronous row inputs |
| col_out | output | 8 | Column data per pad |
| col_oe | output | 8 | Column output-enable per pad (0 = floating) |
| kbd_irq | output | 1 | Level keyboard interrupt |
| kbd_wake | output | 1 | Wake request from the selected rows |

## Verification
A mask write and a synchronised row edge can land on the same clock edge. The bench starts a row rise two edges ahead and commits the mask write on the edge where the rise leaves the synchroniser. It then expects `kbd_wake` to be 1 right after that edge and `kbd_irq` to be 1 one edge later. The second collision is clock enable low against a row change. In that case the bench expects the wake to rise on time, the interrupt to hold at 0, and a concurrent mode write to leave the columns as they were.

// File: rtl/kpd_pkg.sv
// Package: shared types and helpers for the keypad column strobe driver.
// Assumes the mode field width is one bit wider than a column index.
package kpd_pkg;

    typedef enum logic [1:0] {
        DRV_FLOAT  = 2'd0,
        DRV_HIGH   = 2'd1,
        DRV_LOW    = 2'd2,
        DRV_SINGLE = 2'd3
    } drv_kind_e;

    localparam logic [7:0] RESET_MODE = 8'd2;

    // Classify a mode code: top bit set selects one column, else 0/1/other.
    function automatic drv_kind_e classify_mode(input logic top_bit,
                                                input logic [7:0] low_val);
        drv_kind_e k;
        if (top_bit)            k = DRV_SINGLE;
        else if (low_val == 0)  k = DRV_HIGH;
        else if (low_val == 1)  k = DRV_LOW;
        else                    k = DRV_FLOAT;
        return k;
    endfunction

endpackage

// File: rtl/kpd_regs.sv
// Module: kpd_regs
// Holds the column mode and the row-select mask. Writes commit only when
// the peripheral clock enable is high. Readback is combinational.
// Assumes: address 0 = mode (low MODE_W bits), address 1 = mask.
module kpd_regs #(
    parameter int unsigned NUM_ROWS = 8,
    parameter int unsigned MODE_W   = 4,
    parameter int unsigned DATA_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clk_en,
    input  logic                we,
    input  logic                addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic [MODE_W-1:0]   mode_q,
    output logic [NUM_ROWS-1:0] mask_q
);
    import kpd_pkg::*;

    logic commit;
    assign commit = we & clk_en;

    // Mode register: reset to the all-floating code.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= RESET_MODE[MODE_W-1:0];
        else if (commit && !addr)
            mode_q <= wdata[MODE_W-1:0];
    end

    // Mask register: reset to no rows selected.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (commit && addr)
            mask_q <= wdata[NUM_ROWS-1:0];
    end

    // Readback mux, zero-extended.
    always_comb begin
        rdata = '0;
        if (addr) rdata[NUM_ROWS-1:0] = mask_q;
        else      rdata[MODE_W-1:0]   = mode_q;
    end

endmodule

// File: rtl/kpd_col_decode.sv
// Module: kpd_col_decode
// Turns the mode code into per-column data and output-enable vectors.
// Assumes: NUM_COLS is a power of two and MODE_W = log2(NUM_COLS)+1.
module kpd_col_decode #(
    parameter int unsigned NUM_COLS = 8,
    parameter int unsigned MODE_W   = 4
) (
    input  logic [MODE_W-1:0]   mode,
    output logic [NUM_COLS-1:0] col_out,
    output logic [NUM_COLS-1:0] col_oe
);
    import kpd_pkg::*;

    localparam int unsigned IDX_W = MODE_W - 1;

    drv_kind_e kind;
    logic [IDX_W-1:0] idx;
    logic [7:0] low_val;

    assign idx = mode[IDX_W-1:0];

    // Zero-extend the index bits for classification.
    always_comb begin
        low_val = '0;
        low_val[IDX_W-1:0] = idx;
    end

    assign kind = classify_mode(mode[MODE_W-1], low_val);

    // Per-column drive: generate one slice per pad.
    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        // Drive the enable and data for column c from the mode kind.
        always_comb begin
            unique case (kind)
                DRV_HIGH:   begin col_oe[c] = 1'b1; col_out[c] = 1'b1; end
                DRV_LOW:    begin col_oe[c] = 1'b1; col_out[c] = 1'b0; end
                DRV_SINGLE: begin
                    col_oe[c]  = (idx == IDX_W'(c));
                    col_out[c] = (idx == IDX_W'(c));
                end
                default:    begin col_oe[c] = 1'b0; col_out[c] = 1'b0; end
            endcase
        end
    end

endmodule

// File: rtl/kpd_row_sync.sv
// Module: kpd_row_sync
// Multi-stage synchroniser, one chain per row bit. Runs on the always-on
// clock (not gated by the peripheral enable) so wake detection keeps working.
module kpd_row_sync #(
    parameter int unsigned NUM_ROWS = 8,
    parameter int unsigned STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_ROWS-1:0] row_async,
    output logic [NUM_ROWS-1:0] row_sync
);
    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        logic [STAGES-1:0] chain;
        // Shift the raw row bit through the synchroniser chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], row_async[r]};
        end
        assign row_sync[r] = chain[STAGES-1];
    end

endmodule

// File: rtl/keypad_strobe_drv.sv
// Module: keypad_strobe_drv (top)
// Column strobe driver with a masked-row keyboard interrupt and wake request.
// Assumes: synchronous active-low reset; clk runs always, clk_en gates the
// register file and the interrupt flop only.
module keypad_strobe_drv #(
    parameter int unsigned NUM_COLS    = 8,
    parameter int unsigned NUM_ROWS    = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DATA_W      = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clk_en,
    input  logic                reg_we,
    input  logic                reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [NUM_ROWS-1:0] row_in,
    output logic [NUM_COLS-1:0] col_out,
    output logic [NUM_COLS-1:0] col_oe,
    output logic                kbd_irq,
    output logic                kbd_wake
);
    localparam int unsigned MODE_W = $clog2(NUM_COLS) + 1;

    logic [MODE_W-1:0]   mode_q;
    logic [NUM_ROWS-1:0] mask_q;
    logic [NUM_ROWS-1:0] row_sync;
    logic                any_sel;
    logic                irq_q;

    kpd_regs #(
        .NUM_ROWS(NUM_ROWS), .MODE_W(MODE_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
        .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .mode_q(mode_q), .mask_q(mask_q)
    );

    kpd_col_decode #(
        .NUM_COLS(NUM_COLS), .MODE_W(MODE_W)
    ) u_dec (
        .mode(mode_q), .col_out(col_out), .col_oe(col_oe)
    );

    kpd_row_sync #(
        .NUM_ROWS(NUM_ROWS), .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk(clk), .rst_n(rst_n), .row_async(row_in), .row_sync(row_sync)
    );

    // Masked OR of synchronised rows.
    assign any_sel = |(row_sync & mask_q);

    // Level interrupt flop, frozen while the peripheral clock is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)      irq_q <= 1'b0;
        else if (clk_en) irq_q <= any_sel;
    end

    assign kbd_irq  = irq_q;
    assign kbd_wake = any_sel;

endmodule

// File: rtl/kpd_checker.sv
// Module: kpd_checker
// Temporal checks on the strobe driver, bound into every instance of the top.
module kpd_checker #(
    parameter int unsigned NUM_COLS = 8,
    parameter int unsigned NUM_ROWS = 8,
    parameter int unsigned MODE_W   = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                clk_en,
    input logic [MODE_W-1:0]   mode,
    input logic [NUM_ROWS-1:0] mask,
    input logic [NUM_COLS-1:0] col_out,
    input logic [NUM_COLS-1:0] col_oe,
    input logic                kbd_irq,
    input logic                kbd_wake
);
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (col_oe == '0 && !kbd_irq && !kbd_wake));

    a_r2_all_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == '0) |-> (&col_oe && &col_out));

    a_r5_single_col: assert property (@(posedge clk) disable iff (!rst_n)
        mode[MODE_W-1] |-> ($countones(col_oe) == 1 && col_out == col_oe));

    a_r6_no_mask_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !kbd_wake);

    a_r7_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |=> (kbd_irq == $past(kbd_wake)));

    a_r8_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(kbd_irq));

    a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(mode) && $stable(mask)));

    a_r10_float_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (col_out & ~col_oe) == '0);

endmodule

bind keypad_strobe_drv kpd_checker #(
    .NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS), .MODE_W(MODE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .mode(mode_q), .mask(mask_q),
    .col_out(col_out), .col_oe(col_oe), .kbd_irq(kbd_irq), .kbd_wake(kbd_wake)
);

// File: tb/sim_keypad_strobe_drv.sv
// Directed bench for keypad_strobe_drv: one task per scenario.
module sim_keypad_strobe_drv;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 1'b1;
    logic       reg_we = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [7:0] row_in = 8'h00;
    logic [7:0] col_out, col_oe;
    logic       kbd_irq, kbd_wake;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    keypad_strobe_drv u0 (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .row_in(row_in), .col_out(col_out), .col_oe(col_oe),
        .kbd_irq(kbd_irq), .kbd_wake(kbd_wake)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Register write: commits on the posedge between two negedges.
    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_edges(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_oe(input int code);
        if (code == 0 || code == 1) return 8'hFF;
        if (code >= 8) return 8'(1 << (code - 8));
        return 8'h00;
    endfunction

    function automatic logic [7:0] exp_out(input int code);
        if (code == 0) return 8'hFF;
        if (code >= 8) return 8'(1 << (code - 8));
        return 8'h00;
    endfunction

    task automatic t_reset();
        logic [7:0] d;
        rst_n = 1'b0; row_in = 8'hFF;
        wait_edges(3);
        chk("R1 col_oe", col_oe, 8'h00);
        chk("R1 col_out", col_out, 8'h00);
        chk("R1 irq", kbd_irq, 0);
        chk("R1 wake", kbd_wake, 0);
        rd(1'b0, d); chk("R1 mode", d, 8'h02);
        rd(1'b1, d); chk("R1 mask", d, 8'h00);
        row_in = 8'h00;
        @(negedge clk); rst_n = 1'b1;
        wait_edges(2);
    endtask

    task automatic t_modes();
        for (int c = 0; c < 16; c++) begin
            wr(1'b0, 8'(c));
            if (c == 0) begin
                chk("R2 all high oe", col_oe, exp_oe(c));
                chk("R2 all high out", col_out, exp_out(c));
            end else if (c == 1) begin
                chk("R3 all low oe", col_oe, exp_oe(c));
                chk("R3 all low out", col_out, exp_out(c));
            end else if (c < 8) begin
                chk("R4 float oe", col_oe, exp_oe(c));
                chk("R4 float out", col_out, exp_out(c));
            end else begin
                chk("R5 single oe", col_oe, exp_oe(c));
                chk("R5 single out", col_out, exp_out(c));
            end
            chk("R10 floating bits zero", col_out & ~col_oe, 0);
        end
    endtask

    task automatic t_readback();
        logic [7:0] d;
        wr(1'b0, 8'hFA);
        rd(1'b0, d); chk("R9 mode upper bits dropped", d, 8'h0A);
        chk("R9 mode 0xA drives column 2", col_oe, 8'h04);
        wr(1'b1, 8'h5C);
        rd(1'b1, d); chk("R9 mask readback", d, 8'h5C);
        rd(1'b0, d); chk("R9 mode kept", d, 8'h0A);
    endtask

    task automatic t_masked_rows();
        wr(1'b1, 8'h10);
        @(negedge clk); row_in = 8'hEF;
        wait_edges(3);
        chk("R6 unselected rows ignored wake", kbd_wake, 0);
        chk("R6 unselected rows ignored irq", kbd_irq, 0);
        row_in = 8'h10;
        @(negedge clk);
        chk("R6 one edge not yet", kbd_wake, 0);
        @(negedge clk);
        chk("R6 wake after two edges", kbd_wake, 1);
        chk("R7 irq not yet", kbd_irq, 0);
        @(negedge clk);
        chk("R7 irq one edge after wake", kbd_irq, 1);
        row_in = 8'h00;
        wait_edges(2);
        chk("R6 wake drops", kbd_wake, 0);
        chk("R7 irq still high", kbd_irq, 1);
        @(negedge clk);
        chk("R7 irq clears without write", kbd_irq, 0);
    endtask

    task automatic t_collide_mask_row();
        wr(1'b1, 8'h00);
        row_in = 8'h02;
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 1'b1; reg_wdata = 8'h02;
        @(negedge clk);
        reg_we = 1'b0;
        chk("R6 mask write and row edge same cycle", kbd_wake, 1);
        @(negedge clk);
        chk("R7 irq after collision", kbd_irq, 1);
        row_in = 8'h00;
        wait_edges(3);
        chk("R7 irq released", kbd_irq, 0);
    endtask

    task automatic t_clk_gate();
        logic [7:0] d;
        wr(1'b1, 8'hFF);
        wr(1'b0, 8'h09);
        @(negedge clk);
        clk_en = 1'b0; row_in = 8'h80;
        reg_we = 1'b1; reg_addr = 1'b0; reg_wdata = 8'h00;
        wait_edges(3);
        reg_we = 1'b0;
        chk("R8 wake while gated", kbd_wake, 1);
        chk("R8 irq held while gated", kbd_irq, 0);
        chk("R8 write ignored col_oe", col_oe, 8'h02);
        rd(1'b0, d); chk("R8 mode kept", d, 8'h09);
        clk_en = 1'b1;
        @(negedge clk);
        chk("R8 irq updates after enable", kbd_irq, 1);
        row_in = 8'h00;
        wait_edges(3);
    endtask

    initial begin
        t_reset();
        t_modes();
        t_readback();
        t_masked_rows();
        t_collide_mask_row();
        t_clk_gate();
        t_reset();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule